// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block is the control state machine that sequences self-calibration of a pipelined data converter. After the power-on reset is released it counts out a settling delay for the reference. It then runs one calibration window on its own. After that it waits for the converter pipeline to flush before it declares the output data valid. Each later qualified request pulse on `cal_req` runs the same window-and-flush sequence again.

A request is qualified when `cal_req` is sampled high on at least `MIN_PULSE` consecutive clock edges. Each rising edge of the request produces a one-cycle strobe that clears the calibration registers. The window begins on the falling edge, and only if the pulse was qualified. A qualified request that arrives during a window or a flush restarts the window from zero. While the window runs, the block enables the calibration engine, disables the analog inputs and forces the data outputs to zero. The correction arithmetic and the analog circuits are outside this block; every interval is a counter whose length is a parameter.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While `rst_n` is low, `cal_busy`, `cal_run`, `ain_disable`, `cal_clear` and `data_valid` are 0 and `dout_zero` is 1.
- R2: After `rst_n` is released, `cal_busy` rises with no request, in the cycle that follows the SETTLE_CYC-th rising clock edge.
- R3: `cal_busy` stays high for exactly WINDOW_CYC cycles per window.
- R4: Whenever `cal_busy` is 1, `cal_run`, `ain_disable` and `dout_zero` are also 1. `dout_zero` is 1 whenever `data_valid` is 0.
- R5: `data_valid` rises FLUSH_CYC cycles after `cal_busy` falls, which is WINDOW_CYC+FLUSH_CYC cycles after the window starts. It stays 0 during the flush.
- R6: `cal_clear` is high for exactly one cycle, the cycle after the first clock edge that samples `cal_req` high.
- R7: When a request is sampled high on N >= MIN_PULSE consecutive edges, `cal_busy` is 1 in the cycle after the first edge that samples it low again.
- R8: A request sampled high on fewer than MIN_PULSE edges starts no window. `cal_busy` and `data_valid` keep their values.
- R9: A qualified request whose falling edge comes during a window restarts it, so that `cal_busy` stays high for WINDOW_CYC cycles counted from that falling edge.
- R10: `data_valid` stays 0 from reset until the first window and its flush have completed.
- R11: `cal_busy` and `data_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cal_req | input | 1 | Calibration request pulse, synchronous to clk |
| cal_busy | output | 1 | High during the calibration window |
| cal_clear | output | 1 | One-cycle strobe that clears the calibration registers |
| cal_run | output | 1 | Enable for the calibration engine |
| ain_disable | output | 1 | Disables the analog inputs |
| dout_zero | output | 1 | Forces the data outputs to zero |
| data_valid | output | 1 | Output data is calibrated and valid |

## Verification
The assertions assume that `cal_req` is synchronous to `clk` and settles well before each rising edge. They also assume that reset is held low from time zero. The bench therefore changes `cal_req` and `rst_n` only on falling clock edges. It keeps each restart request short enough that its falling edge comes inside the window it interrupts. The parameters are shortened so that full windows and flushes fit in a short run, and the expected cycle of every transition is derived from them.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        SEQ_SETTLE = 2'd0,
        SEQ_WINDOW = 2'd1,
        SEQ_FLUSH  = 2'd2,
        SEQ_READY  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_cal_req_qual.sv
module adc_cal_req_qual #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic clr,
    output logic start
);
    localparam int WW = $clog2(MIN_PULSE + 1);
    localparam logic [WW-1:0] WMAX = WW'(MIN_PULSE);

    typedef struct packed {
        logic          req;
        logic [WW-1:0] wid;
        logic          clr;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.req = req;
        nxt_d.clr = req & ~cur_q.req;
        if (!req)
            nxt_d.wid = '0;
        else if (!cur_q.req)
            nxt_d.wid = WW'(1);
        else if (cur_q.wid < WMAX)
            nxt_d.wid = cur_q.wid + WW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign clr   = cur_q.clr;
    assign start = ~req & cur_q.req & (cur_q.wid >= WMAX);

    // R6: the clear strobe never lasts two cycles
    p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);

    // R6: a strobe only follows an edge that sampled the request high
    p_clear_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr) |-> $past(req));

endmodule

// File: rtl/adc_cal_seq_fsm.sv
module adc_cal_seq_fsm
    import adc_cal_pkg::*;
#(
    parameter int SETTLE_CYC = 221,
    parameter int WINDOW_CYC = 32768,
    parameter int FLUSH_CYC  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_e state
);
    localparam int MAXC = (SETTLE_CYC > WINDOW_CYC)
                        ? ((SETTLE_CYC > FLUSH_CYC) ? SETTLE_CYC : FLUSH_CYC)
                        : ((WINDOW_CYC > FLUSH_CYC) ? WINDOW_CYC : FLUSH_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] WINDOW_LAST = CW'(WINDOW_CYC - 1);
    localparam logic [CW-1:0] FLUSH_LAST  = CW'(FLUSH_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            SEQ_SETTLE: begin
                if (cur_q.cnt == SETTLE_LAST) begin
                    nxt_d.st  = SEQ_WINDOW;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            SEQ_WINDOW: begin
                if (cur_q.cnt == WINDOW_LAST) begin
                    nxt_d.st  = SEQ_FLUSH;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            SEQ_FLUSH: begin
                if (cur_q.cnt == FLUSH_LAST) begin
                    nxt_d.st  = SEQ_READY;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            default: nxt_d.cnt = '0;
        endcase
        if (start) begin
            nxt_d.st  = SEQ_WINDOW;
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '{st: SEQ_SETTLE, cnt: '0};
        else
            cur_q <= nxt_d;
    end

    assign state = cur_q.st;

    // R3: a window ends only after its full count
    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_q.st) == SEQ_WINDOW && cur_q.st == SEQ_FLUSH)
        |-> $past(cur_q.cnt) == WINDOW_LAST);

    // R7: a qualified start always leads to a fresh window
    p_start_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_q.st == SEQ_WINDOW && cur_q.cnt == '0));

    // R8: with no start, the ready state is held
    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == SEQ_READY && !start) |=> cur_q.st == SEQ_READY);

endmodule

// File: rtl/adc_cal_out_decode.sv
module adc_cal_out_decode
    import adc_cal_pkg::*;
(
    input  seq_state_e state,
    output logic       busy,
    output logic       run,
    output logic       ain_off,
    output logic       zero,
    output logic       valid
);
    always_comb begin
        busy    = (state == SEQ_WINDOW);
        run     = (state == SEQ_WINDOW);
        ain_off = (state == SEQ_WINDOW);
        valid   = (state == SEQ_READY);
        zero    = (state != SEQ_READY);
    end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int SETTLE_CYC = 221,
    parameter int WINDOW_CYC = 32768,
    parameter int FLUSH_CYC  = 7,
    parameter int MIN_PULSE  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_req,
    output logic cal_busy,
    output logic cal_clear,
    output logic cal_run,
    output logic ain_disable,
    output logic dout_zero,
    output logic data_valid
);
    logic       start;
    seq_state_e state;

    adc_cal_req_qual #(
        .MIN_PULSE(MIN_PULSE)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cal_req),
        .clr   (cal_clear),
        .start (start)
    );

    adc_cal_seq_fsm #(
        .SETTLE_CYC(SETTLE_CYC),
        .WINDOW_CYC(WINDOW_CYC),
        .FLUSH_CYC (FLUSH_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state)
    );

    adc_cal_out_decode u_dec (
        .state   (state),
        .busy    (cal_busy),
        .run     (cal_run),
        .ain_off (ain_disable),
        .zero    (dout_zero),
        .valid   (data_valid)
    );

    // R4: engine enabled, inputs off and data forced to zero during the window
    p_window_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (cal_run && ain_disable && dout_zero));

    // R11: busy and valid are exclusive
    p_busy_valid_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_busy && data_valid));

    // R5: valid is entered only from the flush wait, never directly after busy
    p_valid_after_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(state) == SEQ_FLUSH && !$past(cal_busy)));

    // R10: once valid, it drops only because a new window started
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid) |-> cal_busy);

endmodule

// File: tb/sim_adc_cal_sequencer.sv
module sim_adc_cal_sequencer;

    localparam int SETTLE = 12;
    localparam int WIN    = 40;
    localparam int FL     = 7;
    localparam int MINP   = 2;

    typedef struct packed {
        logic [7:0] width;
        logic       starts;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{width: 8'd2, starts: 1'b1},
        '{width: 8'd1, starts: 1'b0},
        '{width: 8'd3, starts: 1'b1},
        '{width: 8'd1, starts: 1'b0},
        '{width: 8'd6, starts: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_req = 1'b0;
    logic cal_busy, cal_clear, cal_run, ain_disable, dout_zero, data_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc_cal_sequencer #(
        .SETTLE_CYC(SETTLE),
        .WINDOW_CYC(WIN),
        .FLUSH_CYC (FL),
        .MIN_PULSE (MINP)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_req    (cal_req),
        .cal_busy   (cal_busy),
        .cal_clear  (cal_clear),
        .cal_run    (cal_run),
        .ain_disable(ain_disable),
        .dout_zero  (dout_zero),
        .data_valid (data_valid)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive a request high for w edges; checks the clear strobe (R6).
    // Returns at the falling clock edge where cal_req has just been lowered.
    task automatic pulse(input int w);
        cal_req = 1'b1;
        @(negedge clk);
        chk(cal_clear, 1'b1, "R6 clear after rise");
        for (int i = 1; i < w; i++) begin
            @(negedge clk);
            chk(cal_clear, 1'b0, "R6 clear single cycle");
        end
        cal_req = 1'b0;
    endtask

    // Follow a started window from the falling edge of the request.
    task automatic follow_window(input string tag);
        int busy_bad;
        busy_bad = 0;
        for (int k = 1; k <= WIN + FL + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk(cal_busy, 1'b1, {tag, " R7 busy after fall"});
                chk(cal_run & ain_disable & dout_zero, 1'b1, {tag, " R4 window outputs"});
            end
            if (k <= WIN && cal_busy !== 1'b1) busy_bad++;
            if (k == WIN + 1) begin
                chk(cal_busy, 1'b0, {tag, " R3 busy ends"});
                chk(data_valid, 1'b0, {tag, " R5 flush not valid"});
                chk(dout_zero, 1'b1, {tag, " R4 zero in flush"});
            end
            if (k == WIN + FL) chk(data_valid, 1'b0, {tag, " R5 valid late edge"});
            if (k == WIN + FL + 1) chk(data_valid, 1'b1, {tag, " R5 valid rises"});
        end
        chk(busy_bad == 0, 1'b1, {tag, " R3 busy held whole window"});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cal_busy, 1'b0, "R1 busy in reset");
        chk(cal_clear | cal_run | ain_disable, 1'b0, "R1 strobes in reset");
        chk(data_valid, 1'b0, "R1 valid in reset");
        chk(dout_zero, 1'b1, "R1 zero in reset");
        rst_n = 1'b1;

        // R2, R10: power-on settle then automatic window
        for (int k = 1; k <= SETTLE + WIN + FL; k++) begin
            @(negedge clk);
            if (k == SETTLE - 1) chk(cal_busy, 1'b0, "R2 still settling");
            if (k == SETTLE) chk(cal_busy, 1'b1, "R2 auto window starts");
            if (k == SETTLE + WIN - 1) chk(cal_busy, 1'b1, "R3 power-on window last");
            if (k == SETTLE + WIN) chk(cal_busy, 1'b0, "R3 power-on window ends");
            if (k == SETTLE + WIN + FL - 1) chk(data_valid, 1'b0, "R10 valid held low");
            if (k == SETTLE + WIN + FL) chk(data_valid, 1'b1, "R10 first valid");
        end

        // Table of request widths, walked from the ready state
        for (int v = 0; v < NV; v++) begin
            pulse(int'(VECS[v].width));
            if (VECS[v].starts) begin
                follow_window("R7 table");
            end else begin
                @(negedge clk);
                chk(cal_busy, 1'b0, "R8 short pulse no busy");
                chk(data_valid, 1'b1, "R8 short pulse valid kept");
                repeat (2) @(negedge clk);
                chk(cal_busy, 1'b0, "R8 short pulse still idle");
                chk(data_valid, 1'b1, "R8 short pulse valid still");
            end
        end

        // R9: restart during a window
        pulse(2);
        repeat (10) @(negedge clk);
        chk(cal_busy, 1'b1, "R9 in first window");
        pulse(3);
        follow_window("R9 restart");

        // R8: short pulse during a window leaves the window length alone
        pulse(2);
        for (int k = 1; k <= WIN + 1; k++) begin
            @(negedge clk);
            if (k == 5) cal_req = 1'b1;
            if (k == 6) cal_req = 1'b0;
            if (k == WIN) chk(cal_busy, 1'b1, "R8 window unchanged last");
            if (k == WIN + 1) chk(cal_busy, 1'b0, "R8 window unchanged end");
        end

        // R11 spot check in ready
        repeat (FL + 2) @(negedge clk);
        chk(cal_busy & data_valid, 1'b0, "R11 exclusive");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule